// File: doc/BRIEF.md
# Nine-Bit Multiprocessor UART Core

This block is a full-duplex asynchronous serial port. Every frame carries eight data bits and one further data bit whose transmitted value comes from the host. That extra bit can serve as a parity bit or as a marker that separates address frames from data frames on a shared multidrop line. The bit rate is fixed at one of two fractions of the block clock, one bit per 64 clocks or one bit per 32 clocks, selected by a single input.

On the host side there is a plain parallel register interface. Writing a byte starts a transmission. A pair of completion flags, each cleared by its own strobe, report a finished transmit and an accepted receive. An interrupt output is raised from either flag while interrupts are enabled. The receiver oversamples the line sixteen times per bit, rejects spurious start edges, and decides each bit by a two-of-three vote around the bit centre.

In multiprocessor mode the receiver passes a frame to the host only when it is an address frame (ninth bit set) and its byte matches a local address under a care mask. Every other frame is dropped silently. Nodes that were not addressed therefore see no data traffic.

Top module: `uart9_core`

## Requirements
- R1: The serial output rests at 1 and sends each frame as 11 bits in this order: a 0 start bit, the data byte least significant bit first, the value of `tx_bit9` captured at the write, then a 1 stop bit.
- R2: With `rate_fast` = 0 every bit lasts 64 clock cycles; with `rate_fast` = 1 every bit lasts 32 cycles. This applies to both directions.
- R3: A `tx_wr` pulse while the transmitter is idle drives the start bit from the next cycle. A `tx_wr` pulse while a frame (including its stop bit) is in progress is ignored.
- R4: `tx_done` becomes 1 in the first cycle of the stop bit and stays set until a `tx_done_clr` pulse. If a set and a clear fall on the same cycle, the set wins.
- R5: A falling edge on `rxd` starts a reception only while `rx_en` = 1. With `rx_en` = 0 a whole frame leaves the receive outputs unchanged.
- R6: The start bit is re-checked at its centre. A low pulse shorter than half a bit is discarded and produces no frame.
- R7: Each received bit is the majority of three samples taken around its centre, so a one-clock glitch at mid-bit does not change it.
- R8: When `rx_done` = 0 and `mp_en` = 0, a finished frame loads the byte into `rx_data` and the ninth bit into `rx_bit9`, and sets `rx_done`. The value of the received stop bit has no effect on acceptance.
- R9: While `rx_done` = 1 a finished frame is dropped: `rx_data`, `rx_bit9` and `rx_done` keep their values.
- R10: With `mp_en` = 1 a frame is accepted only if its ninth bit is 1 and its byte equals `local_addr` in every position where `addr_mask` is 1; positions where the mask is 0 are ignored.
- R11: `irq` is 1 exactly when `irq_en` = 1 and at least one of `tx_done` and `rx_done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_fast | input | 1 | 1: 32 clocks per bit, 0: 64 clocks per bit |
| tx_wr | input | 1 | One-cycle strobe that writes `tx_data` and starts a frame |
| tx_data | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth bit to transmit, captured at the write |
| rx_en | input | 1 | Allows new receptions to begin |
| mp_en | input | 1 | Enables the address filter of multiprocessor mode |
| local_addr | input | 8 | Address of this node |
| addr_mask | input | 8 | Care mask for the address compare (1 = compare) |
| tx_done_clr | input | 1 | Clears `tx_done` |
| rx_done_clr | input | 1 | Clears `rx_done` |
| irq_en | input | 1 | Interrupt enable |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| tx_done | output | 1 | Transmit-complete flag |
| rx_done | output | 1 | Receive-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rate_fast` changes only while both directions are idle, since the bit counters compare against the current rate. They also assume that `tx_wr` and the clear strobes last one cycle each. The stimulus changes the rate only after a frame and its settling time are over, and drives all strobes as single-cycle pulses on the falling clock edge. The receive line is driven with whole bit periods matching the selected rate; only the glitch and short-pulse cases break that pattern, and they do so deliberately.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  // two-of-three vote over the centre samples of one bit
  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction

  // masked compare: only positions with a 1 in the mask must agree
  function automatic logic addr_hit(input logic [31:0] rx_byte,
                                    input logic [31:0] addr,
                                    input logic [31:0] mask);
    return ((rx_byte ^ addr) & mask) == 32'd0;
  endfunction

endpackage

// File: rtl/uart9_flag.sv
module uart9_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // a set always wins over a simultaneous clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);

endmodule

// File: rtl/uart9_tick.sv
module uart9_tick #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  input  logic restart,
  output logic tick
);

  localparam int CW = $clog2(SLOW_DIV + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
  assign tick = !restart && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (cnt == lim)   cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DATA_W   = 8,
  parameter int FAST_BIT = 32,
  parameter int SLOW_BIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  input  logic              bit9,
  output logic              txd,
  output logic              busy,
  output logic              stop_start
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int BCW     = $clog2(SLOW_BIT + 1);
  localparam int IW      = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_q;
  logic [BCW-1:0]     cnt;
  logic [IW-1:0]      idx;
  logic [BCW-1:0]     last;
  logic               bit_end;

  assign last       = fast ? BCW'(FAST_BIT - 1) : BCW'(SLOW_BIT - 1);
  assign bit_end    = busy && (cnt == last);
  assign stop_start = bit_end && (idx == IW'(FRAME_W - 2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      idx     <= '0;
      txd     <= 1'b1;
      frame_q <= '1;
    end else if (!busy) begin
      if (wr) begin
        busy    <= 1'b1;
        cnt     <= '0;
        idx     <= '0;
        txd     <= 1'b0;
        frame_q <= {1'b1, bit9, data, 1'b0};
      end
    end else if (bit_end) begin
      cnt <= '0;
      if (idx == IW'(FRAME_W - 1)) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        idx     <= idx + 1'b1;
        txd     <= frame_q[1];
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // line rests at mark between frames
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // a write during a frame leaves the frame being sent untouched
  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && !bit_end) |=> $stable(frame_q));

  // the stop bit is a mark
  p_stop_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_start |=> txd);

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int FAST_BIT = 32,
  parameter int SLOW_BIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast,
  input  logic              rx_en,
  input  logic              mp_en,
  input  logic [DATA_W-1:0] local_addr,
  input  logic [DATA_W-1:0] addr_mask,
  input  logic              flag_set,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              accept
);

  localparam int SW  = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam int NB  = DATA_W + 1;
  localparam int CBW = $clog2(NB + 1);

  rx_state_t         state;
  logic              s1, s2;
  logic [SW-1:0]     sc;
  logic [2:0]        votes;
  logic [CBW-1:0]    bcnt;
  logic [DATA_W:0]   shreg;
  logic              tick;
  logic              start_det;
  logic              bit_end;
  logic              vote_now;
  logic              majority;
  logic              frame_done;
  logic              match;

  assign start_det  = (state == RX_IDLE) && rx_en && !s2;
  assign bit_end    = tick && (sc == SW'(OVS - 1));
  assign vote_now   = tick && (sc >= SW'(MID - 1)) && (sc <= SW'(MID + 1));
  assign majority   = maj3(votes);
  assign frame_done = (state == RX_STOP) && tick && (sc == SW'(MID + 1));
  assign match      = addr_hit(32'(shreg[DATA_W-1:0]), 32'(local_addr), 32'(addr_mask));
  assign accept     = frame_done && !flag_set && (!mp_en || (shreg[DATA_W] && match));

  uart9_tick #(
    .FAST_DIV (FAST_BIT / OVS),
    .SLOW_DIV (SLOW_BIT / OVS)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .fast    (fast),
    .restart (start_det),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      sc    <= '0;
      votes <= 3'b111;
      bcnt  <= '0;
      shreg <= '0;
    end else begin
      if (vote_now) votes <= {votes[1:0], s2};
      if (tick)     sc    <= sc + 1'b1;
      unique case (state)
        RX_IDLE: begin
          if (start_det) begin
            state <= RX_START;
            sc    <= '0;
          end
        end
        RX_START: begin
          if (bit_end) begin
            bcnt  <= '0;
            state <= majority ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            shreg <= {majority, shreg[DATA_W:1]};
            bcnt  <= bcnt + 1'b1;
            if (bcnt == CBW'(NB - 1)) state <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (frame_done) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_bit9 <= 1'b0;
    end else if (accept) begin
      rx_data <= shreg[DATA_W-1:0];
      rx_bit9 <= shreg[DATA_W];
    end
  end

  // receiver cannot leave idle while disabled
  p_en_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && !rx_en) |=> (state == RX_IDLE));

  // nothing is accepted while the previous frame is unread
  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> !accept);

  // outputs only move on an accepted frame
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(rx_data) && $stable(rx_bit9)));

  // in multiprocessor mode only address frames get through
  p_mp_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mp_en) |-> shreg[DATA_W]);

  // a frame can only end in the stop state
  p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (state == RX_IDLE));

endmodule

// File: rtl/uart9_core.sv
module uart9_core #(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int FAST_BIT = 32,
  parameter int SLOW_BIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_fast,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_bit9,
  input  logic              rx_en,
  input  logic              mp_en,
  input  logic [DATA_W-1:0] local_addr,
  input  logic [DATA_W-1:0] addr_mask,
  input  logic              tx_done_clr,
  input  logic              rx_done_clr,
  input  logic              irq_en,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              tx_done,
  output logic              rx_done,
  output logic              irq
);

  logic tx_busy;
  logic tx_stop_start;
  logic rx_accept;

  uart9_tx #(
    .DATA_W   (DATA_W),
    .FAST_BIT (FAST_BIT),
    .SLOW_BIT (SLOW_BIT)
  ) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast       (rate_fast),
    .wr         (tx_wr),
    .data       (tx_data),
    .bit9       (tx_bit9),
    .txd        (txd),
    .busy       (tx_busy),
    .stop_start (tx_stop_start)
  );

  uart9_rx #(
    .DATA_W   (DATA_W),
    .OVS      (OVS),
    .FAST_BIT (FAST_BIT),
    .SLOW_BIT (SLOW_BIT)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast       (rate_fast),
    .rx_en      (rx_en),
    .mp_en      (mp_en),
    .local_addr (local_addr),
    .addr_mask  (addr_mask),
    .flag_set   (rx_done),
    .rxd        (rxd),
    .rx_data    (rx_data),
    .rx_bit9    (rx_bit9),
    .accept     (rx_accept)
  );

  uart9_flag u_tx_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (tx_stop_start),
    .clr   (tx_done_clr),
    .q     (tx_done)
  );

  uart9_flag u_rx_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (rx_accept),
    .clr   (rx_done_clr),
    .q     (rx_done)
  );

  assign irq = irq_en && (tx_done || rx_done);

  // the transmit flag only rises as the stop bit begins
  p_txdone_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(tx_stop_start));

  // the receive flag only rises after an accepted frame
  p_rxdone_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(rx_accept));

  // interrupt needs a pending flag behind it
  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tx_done || rx_done));

  // the transmit flag is raised while the line is still in the frame
  p_flag_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop_start |-> tx_busy);

endmodule

// File: tb/uart9_core_test.sv
module uart9_core_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_fast = 1'b1;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_bit9 = 1'b0;
  logic       rx_en = 1'b0;
  logic       mp_en = 1'b0;
  logic [7:0] local_addr = 8'h00;
  logic [7:0] addr_mask = 8'hFF;
  logic       tx_done_clr = 1'b0;
  logic       rx_done_clr = 1'b0;
  logic       irq_en = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  logic [7:0] rx_data;
  logic       rx_bit9;
  logic       tx_done;
  logic       rx_done;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart9_core uut (
    .clk (clk), .rst_n (rst_n), .rate_fast (rate_fast),
    .tx_wr (tx_wr), .tx_data (tx_data), .tx_bit9 (tx_bit9),
    .rx_en (rx_en), .mp_en (mp_en), .local_addr (local_addr),
    .addr_mask (addr_mask), .tx_done_clr (tx_done_clr),
    .rx_done_clr (rx_done_clr), .irq_en (irq_en), .rxd (rxd),
    .txd (txd), .rx_data (rx_data), .rx_bit9 (rx_bit9),
    .tx_done (tx_done), .rx_done (rx_done), .irq (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bit_len(input logic fast);
    return fast ? 32 : 64;
  endfunction

  // ---------------- transmit reference model ----------------
  int         since = 1000000;
  logic [10:0] mframe = '1;
  logic       m_tx_done = 1'b0;
  int         m_len = 32;

  always @(posedge clk) begin
    if (!rst_n) begin
      since = 1000000;
      m_tx_done = 1'b0;
    end else begin
      automatic bit busy_before = since < 11 * m_len;
      automatic bit set_flag = busy_before && (since == 10 * m_len - 1);
      if (!busy_before && tx_wr) begin
        since  = 0;
        m_len  = bit_len(rate_fast);
        mframe = {1'b1, tx_bit9, tx_data, 1'b0};
      end else if (busy_before) begin
        since = since + 1;
      end
      if (set_flag)         m_tx_done = 1'b1;
      else if (tx_done_clr) m_tx_done = 1'b0;
    end
  end

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic int exp_txd = (since < 11 * m_len) ? int'(mframe[since / m_len]) : 1;
      check("R1 R2 R3 txd", int'(txd), exp_txd);
      check("R4 tx_done", int'(tx_done), int'(m_tx_done));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic write_tx(input logic [7:0] d, input logic b9);
    @(negedge clk);
    tx_data = d; tx_bit9 = b9; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic pulse_tx_clr();
    @(negedge clk); tx_done_clr = 1'b1;
    @(negedge clk); tx_done_clr = 1'b0;
  endtask

  task automatic pulse_rx_clr();
    @(negedge clk); rx_done_clr = 1'b1;
    @(negedge clk); rx_done_clr = 1'b0;
  endtask

  // drive one frame on rxd; stop_len clocks of stop value, glitch_bit < 0 for none
  task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop_v,
                            input int stop_len, input int glitch_bit);
    automatic int L = bit_len(rate_fast);
    automatic logic [9:0] bits = {b9, d};
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      automatic logic v = (i == 0) ? 1'b0 : bits[i-1];
      for (int c = 0; c < L; c++) begin
        rxd = (i == glitch_bit && c == L / 2) ? ~v : v;
        @(negedge clk);
      end
    end
    for (int c = 0; c < stop_len; c++) begin
      rxd = stop_v;
      @(negedge clk);
    end
    rxd = 1'b1;
    repeat (L + 8) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset txd", int'(txd), 1);
    check("R8 reset rx_done", int'(rx_done), 0);
    check("R11 reset irq", int'(irq), 0);
    check("R8 reset rx_data", int'(rx_data), 0);

    // R1 R2 R3 R4: fast frame, a write in the middle is ignored
    rate_fast = 1'b1;
    write_tx(8'hA5, 1'b1);
    repeat (100) @(negedge clk);
    write_tx(8'h0F, 1'b0);
    repeat (11 * 32 + 6) @(negedge clk);
    check("R4 tx_done after frame", int'(tx_done), 1);
    irq_en = 1'b1;
    @(negedge clk);
    check("R11 irq from tx_done", int'(irq), 1);
    irq_en = 1'b0;
    pulse_tx_clr();
    check("R4 tx_done cleared", int'(tx_done), 0);

    // R2: slow frame with ninth bit 0
    rate_fast = 1'b0;
    write_tx(8'h3C, 1'b0);
    repeat (11 * 64 + 6) @(negedge clk);
    pulse_tx_clr();

    // R5: receiver disabled ignores a whole frame
    rate_fast = 1'b1;
    rx_en = 1'b0;
    send_frame(8'h77, 1'b1, 1'b1, 32, -1);
    check("R5 rx_done while disabled", int'(rx_done), 0);
    check("R5 rx_data while disabled", int'(rx_data), 0);

    // R8: plain accept
    rx_en = 1'b1;
    send_frame(8'h5A, 1'b0, 1'b1, 32, -1);
    check("R8 rx_done set", int'(rx_done), 1);
    check("R8 rx_data", int'(rx_data), 8'h5A);
    check("R8 rx_bit9", int'(rx_bit9), 0);
    irq_en = 1'b1;
    @(negedge clk);
    check("R11 irq from rx_done", int'(irq), 1);

    // R9: flag still set, next frame dropped
    send_frame(8'h11, 1'b1, 1'b1, 32, -1);
    check("R9 rx_data kept", int'(rx_data), 8'h5A);
    check("R9 rx_bit9 kept", int'(rx_bit9), 0);
    check("R9 rx_done kept", int'(rx_done), 1);

    // R8: stop bit received as 0 is still accepted
    pulse_rx_clr();
    check("R8 rx_done cleared", int'(rx_done), 0);
    send_frame(8'hC3, 1'b1, 1'b0, 32 / 2 + 4, -1);
    check("R8 bad stop accepted flag", int'(rx_done), 1);
    check("R8 bad stop data", int'(rx_data), 8'hC3);
    check("R8 bad stop bit9", int'(rx_bit9), 1);

    // R6: short low pulse is a false start
    pulse_rx_clr();
    @(negedge clk);
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * 32) @(negedge clk);
    check("R6 false start flag", int'(rx_done), 0);
    check("R6 false start data", int'(rx_data), 8'hC3);

    // R7: one-clock glitch at mid-bit, slow rate
    rate_fast = 1'b0;
    send_frame(8'hF0, 1'b0, 1'b1, 64, 6);
    check("R7 glitch flag", int'(rx_done), 1);
    check("R7 glitch data", int'(rx_data), 8'hF0);
    pulse_rx_clr();
    send_frame(8'h0F, 1'b1, 1'b1, 64, 2);
    check("R7 glitch data low run", int'(rx_data), 8'h0F);
    check("R7 glitch bit9", int'(rx_bit9), 1);
    pulse_rx_clr();

    // R10: multiprocessor filter
    rate_fast = 1'b1;
    mp_en = 1'b1; local_addr = 8'h4B; addr_mask = 8'hFF;
    send_frame(8'h4B, 1'b0, 1'b1, 32, -1);
    check("R10 data frame dropped", int'(rx_done), 0);
    send_frame(8'h4C, 1'b1, 1'b1, 32, -1);
    check("R10 wrong address dropped", int'(rx_done), 0);
    check("R10 data unchanged", int'(rx_data), 8'h0F);
    send_frame(8'h4B, 1'b1, 1'b1, 32, -1);
    check("R10 matching address flag", int'(rx_done), 1);
    check("R10 matching address data", int'(rx_data), 8'h4B);
    pulse_rx_clr();
    local_addr = 8'h40; addr_mask = 8'hF0;
    send_frame(8'h4F, 1'b1, 1'b1, 32, -1);
    check("R10 masked match flag", int'(rx_done), 1);
    check("R10 masked match data", int'(rx_data), 8'h4F);
    pulse_rx_clr();
    send_frame(8'h5F, 1'b1, 1'b1, 32, -1);
    check("R10 masked miss flag", int'(rx_done), 0);
    check("R10 masked miss data", int'(rx_data), 8'h4F);

    // R11: enable gates the interrupt
    send_frame(8'h40, 1'b1, 1'b1, 32, -1);
    irq_en = 1'b1;
    @(negedge clk);
    check("R11 irq enabled", int'(irq), 1);
    irq_en = 1'b0;
    @(negedge clk);
    check("R11 irq masked", int'(irq), 0);

    repeat (10) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule